// File: doc/BRIEF.md
# 100 Mb/s Transmit Code-Group Encoder

This block sits on the transmit path of a 100 Mb/s physical layer. Once per 25 MHz cycle it accepts a 4-bit nibble together with a valid flag and an error flag. It produces one 5-bit code-group per cycle. The serializer and line coder that follow take the code-groups as they are.

Between frames the encoder sends the idle code-group. The first two nibbles of a frame are preamble, and the encoder overwrites them with the start-of-stream pair J then K. After that, each nibble is translated through the fixed 4B/5B table. If the error flag is high on a data nibble, the HALT code-group is sent in its place. When valid drops, the encoder sends the end-of-stream pair T then R, and then returns to idle.

The output is a register, so every code-group appears exactly one clock after the nibble that caused it.

Top module: `pcs_tx_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, `code_out` becomes the idle code-group 5'b11111 on that edge, whatever the other inputs are.
- R2: While no frame is in progress and `nib_valid` is low, `code_out` is 5'b11111. `nib_data` and `nib_err` have no effect on it.
- R3: The first cycle with `nib_valid` high after idle yields J (5'b11000). A second consecutive valid cycle yields K (5'b10001). The nibbles of those two cycles are discarded, and `nib_err` is ignored in both positions.
- R4: From the third valid cycle onward, a nibble with `nib_err` low yields its 4B/5B code. The codes for nibbles 0 through F are: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: In a data position (third valid cycle onward), `nib_err` high yields HALT (5'b00100) instead of the nibble's code.
- R6: The first cycle with `nib_valid` low after a data position yields T (5'b01101). The next cycle yields R (5'b00111). Idle follows unless a new frame starts.
- R7: Every code-group is registered. The code for the inputs sampled at rising edge n is visible on `code_out` just after edge n and holds until edge n+1.
- R8: If `nib_valid` drops in the K position (a frame one nibble long), T replaces K, and R and then idle follow.
- R9: `nib_valid` is ignored in the cycle that produces R. If `nib_valid` is high in the cycle after R, that cycle produces J and starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz nibble clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_valid | input | 1 | Frame nibble present |
| nib_err | input | 1 | Replace the current data nibble with HALT |
| nib_data | input | 4 | Transmit nibble |
| code_out | output | 5 | Registered 5-bit code-group |

## Verification
The checker relies on one fact about the output: every code-group that follows a frame boundary is set by the encoder's own state, and `nib_data` never influences it. It also assumes that the inputs are synchronous and known at each sampling edge. The bench meets this by changing inputs only on the falling edge and never leaving them undriven after reset. Stimulus covers frames of one nibble, frames that carry every nibble value, errors placed on delimiter positions and on data positions, and a restart whose `nib_valid` rises again during the R cycle.

// File: rtl/pcs_tx_enc_pkg.sv
package pcs_tx_enc_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CG_R    = 5'b00111;
  localparam logic [CODE_W-1:0] CG_HALT = 5'b00100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SECOND = 2'd1,
    ST_BODY = 2'd2,
    ST_TAIL = 2'd3
  } frame_st_e;

  typedef enum logic [2:0] {
    PICK_IDLE = 3'd0,
    PICK_J    = 3'd1,
    PICK_K    = 3'd2,
    PICK_DATA = 3'd3,
    PICK_HALT = 3'd4,
    PICK_T    = 3'd5,
    PICK_R    = 3'd6
  } pick_e;
endpackage

// File: rtl/pcs_tx_sym_lookup.sv
module pcs_tx_sym_lookup
  import pcs_tx_enc_pkg::*;
(
  input  logic [NIB_W-1:0]  nib,
  output logic [CODE_W-1:0] sym
);
  always_comb begin
    unique case (nib)
      4'h0: sym = 5'b11110;
      4'h1: sym = 5'b01001;
      4'h2: sym = 5'b10100;
      4'h3: sym = 5'b10101;
      4'h4: sym = 5'b01010;
      4'h5: sym = 5'b01011;
      4'h6: sym = 5'b01110;
      4'h7: sym = 5'b01111;
      4'h8: sym = 5'b10010;
      4'h9: sym = 5'b10011;
      4'hA: sym = 5'b10110;
      4'hB: sym = 5'b10111;
      4'hC: sym = 5'b11010;
      4'hD: sym = 5'b11011;
      4'hE: sym = 5'b11100;
      default: sym = 5'b11101;
    endcase
  end
endmodule

// File: rtl/pcs_tx_frame_ctrl.sv
module pcs_tx_frame_ctrl
  import pcs_tx_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid,
  input  logic  err,
  output pick_e pick
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    pick = PICK_IDLE;
    unique case (st_q)
      ST_IDLE: begin
        if (valid) begin
          pick = PICK_J;
          st_d = ST_SECOND;
        end
      end
      ST_SECOND: begin
        if (valid) begin
          pick = PICK_K;
          st_d = ST_BODY;
        end else begin
          pick = PICK_T;
          st_d = ST_TAIL;
        end
      end
      ST_BODY: begin
        if (valid) begin
          pick = err ? PICK_HALT : PICK_DATA;
        end else begin
          pick = PICK_T;
          st_d = ST_TAIL;
        end
      end
      default: begin
        pick = PICK_R;
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
  import pcs_tx_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nib_valid,
  input  logic              nib_err,
  input  logic [NIB_W-1:0]  nib_data,
  output logic [CODE_W-1:0] code_out
);
  pick_e             pick;
  logic [CODE_W-1:0] data_sym;
  logic [CODE_W-1:0] code_d;

  pcs_tx_frame_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .valid (nib_valid),
    .err   (nib_err),
    .pick  (pick)
  );

  pcs_tx_sym_lookup u_lut (
    .nib (nib_data),
    .sym (data_sym)
  );

  always_comb begin
    unique case (pick)
      PICK_J:    code_d = CG_J;
      PICK_K:    code_d = CG_K;
      PICK_DATA: code_d = data_sym;
      PICK_HALT: code_d = CG_HALT;
      PICK_T:    code_d = CG_T;
      PICK_R:    code_d = CG_R;
      default:   code_d = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) code_out <= CG_IDLE;
    else     code_out <= code_d;
  end
endmodule

// File: rtl/pcs_tx_encoder_chk.sv
module pcs_tx_encoder_chk
  import pcs_tx_enc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              nib_valid,
  input logic              nib_err,
  input logic [NIB_W-1:0]  nib_data,
  input logic [CODE_W-1:0] code_out
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_IDLE && !nib_valid) |=> (code_out == CG_IDLE));

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_J && nib_valid) |=> (code_out == CG_K));

  // R8
  j_then_t_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_J && !nib_valid) |=> (code_out == CG_T));

  // R6
  t_then_r_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_T) |=> (code_out == CG_R));

  // R9
  r_then_j_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_R && nib_valid) |=> (code_out == CG_J));

  // R5
  halt_after_k_chk: assert property (@(posedge clk) disable iff (rst)
    (code_out == CG_K && nib_valid && nib_err) |=> (code_out == CG_HALT));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (code_out == CG_IDLE));

  // R7
  known_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(code_out));
endmodule

bind pcs_tx_encoder pcs_tx_encoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .nib_valid (nib_valid),
  .nib_err   (nib_err),
  .nib_data  (nib_data),
  .code_out  (code_out)
);

// File: tb/pcs_tx_encoder_tb.sv
module pcs_tx_encoder_tb;
  localparam int CLK_PERIOD = 40;
  localparam logic [4:0] I = 5'b11111, J = 5'b11000, K = 5'b10001;
  localparam logic [4:0] T = 5'b01101, R = 5'b00111, H = 5'b00100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nib_valid = 1'b0;
  logic nib_err = 1'b0;
  logic [3:0] nib_data = 4'h0;
  logic [4:0] code_out;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcs_tx_encoder u_dut (
    .clk(clk), .rst(rst), .nib_valid(nib_valid),
    .nib_err(nib_err), .nib_data(nib_data), .code_out(code_out)
  );

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  // drive on falling edge, check just after the next rising edge
  task automatic step(input logic v, input logic e, input logic [3:0] d,
                      input logic [4:0] exp, input string req);
    @(negedge clk);
    nib_valid = v; nib_err = e; nib_data = d;
    @(posedge clk); #1;
    n_chk++;
    if (code_out !== exp) begin
      n_bad++;
      $display("FAIL %s: code_out=%b expected=%b", req, code_out, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; nib_valid = 1'b1; nib_err = 1'b1; nib_data = 4'hA;
    @(posedge clk); #1;
    n_chk++;
    if (code_out !== I) begin
      n_bad++;
      $display("FAIL R1: code_out=%b expected=%b", code_out, I);
    end
    @(negedge clk);
    rst = 1'b0; nib_valid = 1'b0; nib_err = 1'b0;
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++) step(1'b0, i[0], 4'(i * 3), I, "R2");
  endtask

  task automatic t_full_frame();
    step(1'b1, 1'b0, 4'h5, J, "R3");
    step(1'b1, 1'b0, 4'h5, K, "R3");
    for (int n = 0; n < 16; n++)
      step(1'b1, 1'b0, 4'(n), ref_code(4'(n)), "R4/R7");
    step(1'b0, 1'b0, 4'h0, T, "R6");
    step(1'b0, 1'b0, 4'h0, R, "R6");
    step(1'b0, 1'b0, 4'h0, I, "R6");
  endtask

  task automatic t_error_frame();
    step(1'b1, 1'b1, 4'h5, J, "R3 err on J");
    step(1'b1, 1'b1, 4'h5, K, "R3 err on K");
    step(1'b1, 1'b0, 4'h7, ref_code(4'h7), "R4");
    step(1'b1, 1'b1, 4'h7, H, "R5");
    step(1'b1, 1'b1, 4'h0, H, "R5");
    step(1'b1, 1'b0, 4'hD, ref_code(4'hD), "R4");
    step(1'b0, 1'b1, 4'h0, T, "R6");
    step(1'b0, 1'b0, 4'h0, R, "R6");
    step(1'b0, 1'b1, 4'h3, I, "R2");
  endtask

  task automatic t_short_frame();
    step(1'b1, 1'b0, 4'h5, J, "R8");
    step(1'b0, 1'b0, 4'h5, T, "R8");
    step(1'b0, 1'b0, 4'h0, R, "R8");
    step(1'b0, 1'b0, 4'h0, I, "R8");
  endtask

  task automatic t_restart();
    step(1'b1, 1'b0, 4'h5, J, "R9");
    step(1'b1, 1'b0, 4'h5, K, "R9");
    step(1'b1, 1'b0, 4'h2, ref_code(4'h2), "R9");
    step(1'b0, 1'b0, 4'h0, T, "R9");
    step(1'b1, 1'b0, 4'h9, R, "R9");
    step(1'b1, 1'b0, 4'h5, J, "R9");
    step(1'b1, 1'b0, 4'h5, K, "R9");
    step(1'b1, 1'b0, 4'hB, ref_code(4'hB), "R9");
    step(1'b0, 1'b0, 4'h0, T, "R9");
    step(1'b0, 1'b0, 4'h0, R, "R9");
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_idle();
    t_full_frame();
    t_error_frame();
    t_short_frame();
    t_restart();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule